// File: doc/BRIEF.md
# Backlight PWM Generator with Register Port

This block drives a display backlight. It produces one pulse-width-modulated output and a separate backlight-enable line, and it is programmed through a small byte-wide register port. A host writes three registers: a clock-divider register whose top bit turns the PWM output on, an 8-bit brightness level, and a backlight-enable register. The host can read each register back over the same port.

Inside, a prescaler divides the block clock by a programmable value from 1 to 128. An 8-bit period counter advances once per divided tick, so each period is 256 divided ticks long. The output is high while the counter is below the brightness level. A new brightness level takes effect only at the end of a period. A new divisor takes effect only when the output enable goes from off to on, which restarts the waveform from the start of a period.

Top module: `bl_pwm_gen`

## Requirements
- R1: Register addresses are 0x4B for the divider register, 0x4E for the level register and 0x51 for the backlight register. A read with `bus_sel`=1 and `bus_wr`=0 returns the last value written to the addressed register. Any other address reads as 0x00, and writes to it change nothing.
- R2: After reset, all three registers read 0x00, `pwm_out` is 0 and `bl_en_out` is 0.
- R3: Bit 7 of the divider register enables the PWM. While that bit is 0, `pwm_out` is 0.
- R4: Bits 6:0 of the divider register hold N. Once enabled, the period counter advances every N+1 clocks, and a period lasts 256×(N+1) clocks.
- R5: While enabled, `pwm_out` is 1 when the period counter is below the active level. A level of 0x00 keeps the output low for the whole period. A level of 0xFF keeps it high without a break.
- R6: A write to the level register while the PWM is enabled takes effect only when the period counter wraps from 255 to 0.
- R7: A write that sets bit 7 while the PWM is disabled captures N and the current level, and restarts the waveform at counter 0. A divider write made while the PWM is already enabled leaves the running divisor unchanged.
- R8: Bit 0 of the backlight register drives `bl_en_out`, independently of the PWM enable. Bits 7:1 of that register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which is also the PWM base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when no read is active |
| pwm_out | output | 1 | PWM waveform, active high |
| bl_en_out | output | 1 | Backlight enable |

## Verification
The waveform is compared with the reference model on every clock. The stimuli are a mid-scale level at divisor 1, a level change in the middle of a period, the extreme levels 0x00 and 0xFF, and a divisor of 4. The mid-period level change tells wrap-time latching apart from immediate update. A divider rewrite made while running, and then a disable and re-enable, tell the capture-on-enable rule apart from direct use of the register. Readbacks of the backlight register with its upper bits set, and of an unmapped address after a write to it, separate stored state from decode errors.

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter int ADDR_W = 8,
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 8'h4B,
  parameter logic [ADDR_W-1:0] LVL_ADDR = 8'h4E,
  parameter logic [ADDR_W-1:0] BL_ADDR = 8'h51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              pwm_out,
  output logic              bl_en_out
);
  localparam int PW = DW - 1;
  localparam logic [DW-1:0] FULL = {DW{1'b1}};

  logic [DW-1:0] div_q, lvl_q, act_lvl, cnt;
  logic [PW-1:0] act_div, pre;
  logic          bl_q;

  wire wr_div = bus_sel & bus_wr & (bus_addr == DIV_ADDR);
  wire wr_lvl = bus_sel & bus_wr & (bus_addr == LVL_ADDR);
  wire wr_bl  = bus_sel & bus_wr & (bus_addr == BL_ADDR);
  wire en     = div_q[DW-1];
  wire start  = wr_div & bus_wdata[DW-1] & ~en;
  wire tick   = (pre == act_div);
  wire wrap   = tick & (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0;
      lvl_q <= '0;
      bl_q  <= 1'b0;
    end else begin
      if (wr_div) div_q <= bus_wdata;
      if (wr_lvl) lvl_q <= bus_wdata;
      if (wr_bl)  bl_q  <= bus_wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      act_div <= '0;
      act_lvl <= '0;
    end else if (start) begin
      pre     <= '0;
      cnt     <= '0;
      act_div <= bus_wdata[PW-1:0];
      act_lvl <= lvl_q;
    end else if (!en) begin
      pre <= '0;
      cnt <= '0;
    end else if (tick) begin
      pre <= '0;
      cnt <= cnt + 1'b1;
      if (cnt == FULL) act_lvl <= lvl_q;
    end else begin
      pre <= pre + 1'b1;
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == DIV_ADDR)      bus_rdata = div_q;
      else if (bus_addr == LVL_ADDR) bus_rdata = lvl_q;
      else if (bus_addr == BL_ADDR)  bus_rdata = {{(DW-1){1'b0}}, bl_q};
    end
  end

  assign pwm_out   = en & ((act_lvl == FULL) | (cnt < act_lvl));
  assign bl_en_out = bl_q;

  assert_disable_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div && !bus_wdata[DW-1]) |=> !pwm_out);
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && pre == '0));
  assert_div_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(act_div));
  assert_level_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(act_lvl));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));
  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pre <= act_div));
  assert_bl_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bl |=> (bl_en_out == $past(bus_wdata[0])));
endmodule

// File: tb/bl_pwm_gen_tb.sv
`timescale 1ns/1ps
module bl_pwm_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic pwm_out, bl_en_out;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  bl_pwm_gen dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .bl_en_out(bl_en_out));

  always #10 clk = ~clk;

  // behavioural reference: position p in clocks within the period
  bit m_en, m_bl;
  int m_n, m_duty, m_an, m_aduty, p;

  function automatic bit exp_pwm();
    return m_en && (m_aduty == 255 || (p / (m_an + 1)) < m_aduty);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_bl = 0; m_n = 0; m_duty = 0; m_an = 0; m_aduty = 0; p = 0;
    end else begin
      automatic bit w = bus_sel && bus_wr;
      automatic int old_duty = m_duty;
      automatic bit adv = m_en;
      if (w && bus_addr == 8'h4B) begin
        if (bus_wdata[7] && !m_en) begin
          m_an = bus_wdata[6:0]; p = 0; m_aduty = old_duty; adv = 0;
        end
        if (adv) begin
          p++;
          if (p == 256 * (m_an + 1)) begin p = 0; m_aduty = old_duty; end
        end
        m_en = bus_wdata[7]; m_n = bus_wdata[6:0];
      end else if (adv) begin
        p++;
        if (p == 256 * (m_an + 1)) begin p = 0; m_aduty = old_duty; end
      end
      if (w && bus_addr == 8'h4E) m_duty = bus_wdata;
      if (w && bus_addr == 8'h51) m_bl = bus_wdata[0];
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      checks++;
      if (pwm_out !== exp_pwm()) begin
        errors++;
        $display("FAIL R3 R4 R5 R6 R7 pwm_out at %0t: got %0b exp %0b", $time, pwm_out, exp_pwm());
      end
      checks++;
      if (bl_en_out !== m_bl) begin
        errors++;
        $display("FAIL R8 bl_en_out at %0t: got %0b exp %0b", $time, bl_en_out, m_bl);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2; checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h: got 0x%02h exp 0x%02h", tag, a, bus_rdata, exp);
    end
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run(3);
    @(negedge clk); rst_n = 1;
    checks++;
    if (pwm_out !== 1'b0 || bl_en_out !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset outputs: got %0b%0b exp 00", pwm_out, bl_en_out);
    end
    rd(8'h4B, 8'h00, "R2"); rd(8'h4E, 8'h00, "R2"); rd(8'h51, 8'h00, "R2");
    // R8 backlight independent of pwm enable
    wr(8'h51, 8'h01); rd(8'h51, 8'h01, "R8"); run(5);
    wr(8'h51, 8'hFE); rd(8'h51, 8'h00, "R8"); run(5);
    wr(8'h51, 8'h01);
    // R5 mid level, divisor 1, R6 change mid-period
    wr(8'h4E, 8'h40); rd(8'h4E, 8'h40, "R1");
    wr(8'h4B, 8'h80); rd(8'h4B, 8'h80, "R1");
    run(100); wr(8'h4E, 8'hC0); run(500);
    // R5 extremes
    wr(8'h4E, 8'hFF); run(560);
    wr(8'h4E, 8'h00); run(560);
    wr(8'h4E, 8'h55);
    // R7 divider rewrite while enabled has no effect
    wr(8'h4B, 8'h83); rd(8'h4B, 8'h83, "R7"); run(600);
    // R3 disable holds output low
    wr(8'h4B, 8'h03); run(40);
    // R4 divisor 4 after re-enable
    wr(8'h4B, 8'h83); run(2200);
    wr(8'h4B, 8'h00); run(10);
    // R1 unmapped address
    wr(8'h50, 8'hFF); rd(8'h50, 8'h00, "R1");
    rd(8'h4B, 8'h00, "R1"); rd(8'h4E, 8'h55, "R1"); rd(8'h51, 8'h01, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule